// File: doc/BRIEF.md
# I2C Host Status Flag Register

This block keeps the byte-wide status word of an I2C host controller. The bit engine sends it single-cycle event pulses: a byte read has finished, an address or data byte has been sent, the engine has begun holding SCL low, an acknowledge bit has been sampled, arbitration was lost, or a bus protocol violation was seen. It also sends bus-state updates. The block turns these pulses into sticky flags. Software reads the flags as one status value. Two interrupt requests come from the flags, and each is gated by its own enable input.

Software clears the flags in two ways. It can write a one to a flag bit. It can also access the neighbouring host registers, and each flag has its own set of these side clears. The address, data and command registers are not stored here. The block sees only their access strobes.

The two-bit bus-state field is kept by a small state machine. Its states are UNKNOWN (0), IDLE (1), OWNER (2) and BUSY (3). There are three transitions. LOAD is taken from any state when the engine reports a new state, and the machine goes to the reported value. FORCE_IDLE is taken from any state other than IDLE when software writes 01 to the field and the engine reports nothing in that cycle. HOLD covers every other cycle, and the state stays the same.

Top module: `i2c_host_status`

## Requirements
- R1: After reset the status value reads 0x00, and both interrupt outputs are 0.
- R2: A read-done pulse sets the read flag (bit 7) on the next cycle.
- R3: A write-done pulse sets the write flag (bit 6) on the next cycle. This holds even when an arbitration-lost or bus-error pulse arrives in the same cycle.
- R4: A status write with a one in bit 7, 6, 5 or 3 clears that flag.
- R5: The read, write, clock-hold (bit 5) and arbitration-lost (bit 3) flags are cleared by any of these strobes: address write, data read, data write or command write.
- R6: The bus-error flag (bit 2) is cleared only by a status write with bit 2 set or by an address write. Data-register accesses and command writes leave it unchanged.
- R7: Bit 4 takes the sampled acknowledge bit (1 means NACK) whenever the acknowledge-valid input is high. Status writes and register accesses never change it.
- R8: A clock-hold pulse sets bit 5, and an arbitration-lost pulse sets bit 3.
- R9: Writing a zero to any flag bit leaves that flag unchanged.
- R10: If a set event and a clear arrive for the same flag in the same cycle, the flag ends up set.
- R11: Bits 1:0 take the engine's reported state when the update strobe is high. A status write with bits 1:0 = 01 forces IDLE (01). Any other written value is ignored. An engine update in the same cycle takes precedence over the forced IDLE.
- R12: The read interrupt equals bit 7 AND the read-interrupt enable. The write interrupt equals bit 6 AND the write-interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rd_done | input | 1 | Pulse: host byte read finished |
| ev_wr_done | input | 1 | Pulse: address or data byte sent |
| ev_clk_hold | input | 1 | Pulse: engine began holding SCL low |
| ack_valid | input | 1 | Acknowledge bit sampled this cycle |
| ack_bit | input | 1 | Sampled acknowledge level, 1 means NACK |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_bus_err | input | 1 | Pulse: bus protocol violation |
| bs_upd | input | 1 | Bus-state update strobe |
| bs_val | input | 2 | Reported bus state |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 8 | Status register write data |
| adr_wr | input | 1 | Address register write strobe |
| dat_rd | input | 1 | Data register read strobe |
| dat_wr | input | 1 | Data register write strobe |
| cmd_wr | input | 1 | Command field write strobe |
| rd_irq_en | input | 1 | Read interrupt enable |
| wr_irq_en | input | 1 | Write interrupt enable |
| sts_rdata | output | 8 | Status read value |
| rd_irq | output | 1 | Read interrupt request |
| wr_irq | output | 1 | Write interrupt request |

## Verification
The bench uses the package defaults: an eight-bit word, a two-bit state field and five sticky flags. With these, the whole status value and both interrupt outputs fit in a single scoreboard item that is compared every cycle. At these sizes the bench can walk every side-clear strobe against every flag, including the bus-error flag's narrower clear set. It can also reach all four bus states, and it covers the collisions between a set and a clear, and between an engine load and a forced IDLE.

// File: rtl/hs_stat_pkg.sv
package hs_stat_pkg;
    localparam int STS_W  = 8;
    localparam int BS_W   = 2;
    localparam int NFLG   = 5;

    // status bit positions
    localparam int B_RIF  = 7;
    localparam int B_WIF  = 6;
    localparam int B_HOLD = 5;
    localparam int B_RACK = 4;
    localparam int B_ARB  = 3;
    localparam int B_BERR = 2;

    // flag bank indices
    localparam int F_RIF  = 0;
    localparam int F_WIF  = 1;
    localparam int F_HOLD = 2;
    localparam int F_ARB  = 3;
    localparam int F_BERR = 4;

    // flags whose clear also comes from data/command accesses
    localparam logic [NFLG-1:0] SIDE_MASK = 5'b01111;

    localparam logic [BS_W-1:0] BS_FORCE_CODE = 2'b01;

    typedef enum logic [BS_W-1:0] {
        BS_UNKNOWN = 2'd0,
        BS_IDLE    = 2'd1,
        BS_OWNER   = 2'd2,
        BS_BUSY    = 2'd3
    } bus_st_e;
endpackage

// File: rtl/hs_flag_bank.sv
module hs_flag_bank #(
    parameter int              N         = 5,
    parameter logic [N-1:0]    WIDE_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] w1c,
    input  logic         narrow_clr,
    input  logic         wide_clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic clr;
        if (WIDE_MASK[i]) begin : g_wide
            assign clr = w1c[i] | narrow_clr | wide_clr;
        end else begin : g_narrow
            assign clr = w1c[i] | narrow_clr;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set_ev[i])
                q[i] <= 1'b1;
            else if (clr)
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/hs_ack_capture.sv
module hs_ack_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_valid,
    input  logic ack_bit,
    output logic nack_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            nack_q <= 1'b0;
        else if (ack_valid)
            nack_q <= ack_bit;
    end
endmodule

// File: rtl/hs_bus_state_fsm.sv
module hs_bus_state_fsm
    import hs_stat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bs_upd,
    input  logic [BS_W-1:0] bs_val,
    input  logic            force_req,
    output logic [BS_W-1:0] bus_state
);
    bus_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= BS_UNKNOWN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE: begin
                if (bs_upd)
                    state_d = bus_st_e'(bs_val);      // LOAD
            end
            BS_UNKNOWN, BS_OWNER, BS_BUSY: begin
                if (bs_upd)
                    state_d = bus_st_e'(bs_val);      // LOAD
                else if (force_req)
                    state_d = BS_IDLE;                // FORCE_IDLE
            end
            default: state_d = BS_UNKNOWN;
        endcase
    end

    always_comb begin
        bus_state = state_q;
    end
endmodule

// File: rtl/i2c_host_status.sv
module i2c_host_status
    import hs_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_rd_done,
    input  logic             ev_wr_done,
    input  logic             ev_clk_hold,
    input  logic             ack_valid,
    input  logic             ack_bit,
    input  logic             ev_arb_lost,
    input  logic             ev_bus_err,
    input  logic             bs_upd,
    input  logic [1:0]       bs_val,
    input  logic             sts_wr,
    input  logic [7:0]       sts_wdata,
    input  logic             adr_wr,
    input  logic             dat_rd,
    input  logic             dat_wr,
    input  logic             cmd_wr,
    input  logic             rd_irq_en,
    input  logic             wr_irq_en,
    output logic [7:0]       sts_rdata,
    output logic             rd_irq,
    output logic             wr_irq
);
    logic [NFLG-1:0] set_ev, w1c, flg;
    logic            nack_q;
    logic [BS_W-1:0] bus_state;
    logic            force_req;

    always_comb begin
        set_ev         = '0;
        set_ev[F_RIF]  = ev_rd_done;
        set_ev[F_WIF]  = ev_wr_done;
        set_ev[F_HOLD] = ev_clk_hold;
        set_ev[F_ARB]  = ev_arb_lost;
        set_ev[F_BERR] = ev_bus_err;

        w1c            = '0;
        w1c[F_RIF]     = sts_wr & sts_wdata[B_RIF];
        w1c[F_WIF]     = sts_wr & sts_wdata[B_WIF];
        w1c[F_HOLD]    = sts_wr & sts_wdata[B_HOLD];
        w1c[F_ARB]     = sts_wr & sts_wdata[B_ARB];
        w1c[F_BERR]    = sts_wr & sts_wdata[B_BERR];
    end

    assign force_req = sts_wr & (sts_wdata[BS_W-1:0] == BS_FORCE_CODE);

    hs_flag_bank #(
        .N         (NFLG),
        .WIDE_MASK (SIDE_MASK)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_ev     (set_ev),
        .w1c        (w1c),
        .narrow_clr (adr_wr),
        .wide_clr   (dat_rd | dat_wr | cmd_wr),
        .q          (flg)
    );

    hs_ack_capture u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_valid (ack_valid),
        .ack_bit   (ack_bit),
        .nack_q    (nack_q)
    );

    hs_bus_state_fsm u_bs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bs_upd    (bs_upd),
        .bs_val    (bs_val),
        .force_req (force_req),
        .bus_state (bus_state)
    );

    always_comb begin
        sts_rdata               = '0;
        sts_rdata[B_RIF]        = flg[F_RIF];
        sts_rdata[B_WIF]        = flg[F_WIF];
        sts_rdata[B_HOLD]       = flg[F_HOLD];
        sts_rdata[B_RACK]       = nack_q;
        sts_rdata[B_ARB]        = flg[F_ARB];
        sts_rdata[B_BERR]       = flg[F_BERR];
        sts_rdata[BS_W-1:0]     = bus_state;
    end

    assign rd_irq = flg[F_RIF] & rd_irq_en;
    assign wr_irq = flg[F_WIF] & wr_irq_en;
endmodule

// File: rtl/i2c_host_status_chk.sv
module i2c_host_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_rd_done,
    input logic       ev_wr_done,
    input logic       ev_clk_hold,
    input logic       ack_valid,
    input logic       ack_bit,
    input logic       ev_arb_lost,
    input logic       ev_bus_err,
    input logic       bs_upd,
    input logic [1:0] bs_val,
    input logic       sts_wr,
    input logic [7:0] sts_wdata,
    input logic       adr_wr,
    input logic       dat_rd,
    input logic       dat_wr,
    input logic       cmd_wr,
    input logic       rd_irq_en,
    input logic       wr_irq_en,
    input logic [7:0] sts_rdata,
    input logic       rd_irq,
    input logic       wr_irq
);
    p_rif_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rd_done |=> sts_rdata[7]);

    p_wif_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wr_done |=> sts_rdata[6]);

    p_side_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !ev_rd_done) |=> !sts_rdata[7]);

    p_berr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rdata[2] && !adr_wr && !(sts_wr && sts_wdata[2])) |=> sts_rdata[2]);

    p_nack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |=> $stable(sts_rdata[4]));

    p_force_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && sts_wdata[1:0] == 2'b01 && !bs_upd) |=> (sts_rdata[1:0] == 2'b01));

    p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_irq_en |-> !rd_irq);
endmodule

bind i2c_host_status i2c_host_status_chk u_chk (.*);

// File: tb/sim_i2c_host_status.sv
`timescale 1ns/100ps
module sim_i2c_host_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_rd_done = 0, ev_wr_done = 0, ev_clk_hold = 0, ack_valid = 0, ack_bit = 0;
    logic ev_arb_lost = 0, ev_bus_err = 0, bs_upd = 0;
    logic [1:0] bs_val = '0;
    logic sts_wr = 0;
    logic [7:0] sts_wdata = '0;
    logic adr_wr = 0, dat_rd = 0, dat_wr = 0, cmd_wr = 0, rd_irq_en = 0, wr_irq_en = 0;
    logic [7:0] sts_rdata;
    logic rd_irq, wr_irq;

    always #2 clk = ~clk;   // 250 MHz

    i2c_host_status u0 (.*);

    typedef struct {
        logic [7:0] rdata;
        logic       rirq;
        logic       wirq;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // reference model built from the requirements
    logic m_rif = 0, m_wif = 0, m_hold = 0, m_nack = 0, m_arb = 0, m_berr = 0;
    logic [1:0] m_bs = 0;

    function automatic logic [7:0] m_word();
        return {m_rif, m_wif, m_hold, m_nack, m_arb, m_berr, m_bs};
    endfunction

    task automatic clear_inputs();
        ev_rd_done = 0; ev_wr_done = 0; ev_clk_hold = 0; ack_valid = 0; ack_bit = 0;
        ev_arb_lost = 0; ev_bus_err = 0; bs_upd = 0; bs_val = 0;
        sts_wr = 0; sts_wdata = 0; adr_wr = 0; dat_rd = 0; dat_wr = 0; cmd_wr = 0;
    endtask

    // driver: inputs already staged; advance one edge and push expectation
    task automatic cyc(string tag);
        logic side, wide;
        exp_t e;
        side = adr_wr;
        wide = adr_wr | dat_rd | dat_wr | cmd_wr;
        if (ev_rd_done) m_rif = 1; else if ((sts_wr && sts_wdata[7]) || wide) m_rif = 0;
        if (ev_wr_done) m_wif = 1; else if ((sts_wr && sts_wdata[6]) || wide) m_wif = 0;
        if (ev_clk_hold) m_hold = 1; else if ((sts_wr && sts_wdata[5]) || wide) m_hold = 0;
        if (ev_arb_lost) m_arb = 1; else if ((sts_wr && sts_wdata[3]) || wide) m_arb = 0;
        if (ev_bus_err) m_berr = 1; else if ((sts_wr && sts_wdata[2]) || side) m_berr = 0;
        if (ack_valid) m_nack = ack_bit;
        if (bs_upd) m_bs = bs_val; else if (sts_wr && sts_wdata[1:0] == 2'b01) m_bs = 2'b01;
        @(posedge clk);
        #1;
        e.rdata = m_word();
        e.rirq  = m_rif & rd_irq_en;
        e.wirq  = m_wif & wr_irq_en;
        e.tag   = tag;
        sbq.push_back(e);
        @(negedge clk);
        clear_inputs();
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1.5;
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                n_cmp++;
                if (sts_rdata !== e.rdata || rd_irq !== e.rirq || wr_irq !== e.wirq) begin
                    n_bad++;
                    $display("FAIL %s: got sts=%02h rirq=%0b wirq=%0b expected sts=%02h rirq=%0b wirq=%0b",
                             e.tag, sts_rdata, rd_irq, wr_irq, e.rdata, e.rirq, e.wirq);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc("R1");                                   // reset value

        rd_irq_en = 1; wr_irq_en = 1;
        ev_rd_done = 1; cyc("R2");                   // set read flag, irq R12
        sts_wr = 1; sts_wdata = 8'h80; cyc("R4");    // w1c read flag

        ev_rd_done = 1; ev_clk_hold = 1; cyc("R8");
        sts_wr = 1; sts_wdata = 8'h00; cyc("R9");    // zero write keeps flags
        sts_wr = 1; sts_wdata = 8'h20; cyc("R4");    // clears hold only

        ev_wr_done = 1; ev_arb_lost = 1; ev_bus_err = 1; cyc("R3");
        rd_irq_en = 0; cyc("R12");
        sts_wr = 1; sts_wdata = 8'h48; cyc("R4");    // clear wif+arb
        wr_irq_en = 0; ev_wr_done = 1; cyc("R12");

        adr_wr = 1; cyc("R5");                       // clears all incl. bus error R6
        ev_rd_done = 1; ev_wr_done = 1; ev_clk_hold = 1; ev_arb_lost = 1; ev_bus_err = 1; cyc("R8");
        dat_rd = 1; cyc("R5");                       // bus error stays R6
        ev_rd_done = 1; ev_arb_lost = 1; cyc("R8");
        dat_wr = 1; cyc("R5");
        ev_wr_done = 1; ev_clk_hold = 1; cyc("R3");
        cmd_wr = 1; cyc("R6");
        sts_wr = 1; sts_wdata = 8'h04; cyc("R6");    // w1c bus error

        ack_valid = 1; ack_bit = 1; cyc("R7");
        sts_wr = 1; sts_wdata = 8'h10; cyc("R7");
        adr_wr = 1; dat_rd = 1; cmd_wr = 1; cyc("R7");
        ack_valid = 1; ack_bit = 0; cyc("R7");

        ev_rd_done = 1; adr_wr = 1; cyc("R10");
        ev_bus_err = 1; sts_wr = 1; sts_wdata = 8'h04; cyc("R10");
        ev_wr_done = 1; dat_wr = 1; cyc("R10");
        sts_wr = 1; sts_wdata = 8'hFF; cyc("R4"); // clears flags, bs field 11 ignored

        bs_upd = 1; bs_val = 2'd2; cyc("R11");
        sts_wr = 1; sts_wdata = 8'h02; cyc("R11");
        sts_wr = 1; sts_wdata = 8'h03; cyc("R11");
        sts_wr = 1; sts_wdata = 8'h00; cyc("R11");
        sts_wr = 1; sts_wdata = 8'h01; cyc("R11");
        bs_upd = 1; bs_val = 2'd3; sts_wr = 1; sts_wdata = 8'h01; cyc("R11");
        bs_upd = 1; bs_val = 2'd0; cyc("R11");
        sts_wr = 1; sts_wdata = 8'h01; cyc("R11");
        cyc("R11");

        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule